// File: doc/BRIEF.md
# Byte Prefetch Queue with Operation Status

This block is a small byte queue placed between a 16-bit bus interface and an instruction consumer. It keeps its own fetch address and asks the bus side for code when there is room. From an even address it asks for two bytes at once. From an odd address it asks for one byte. It accepts the returned bytes, and the consumer takes bytes off the head while fetching goes on at the same time.

Every clock the block drives a two-bit code that names what happened to the queue in that cycle. The consumer marks the last byte of each instruction as it pops it. The byte popped after that is reported as the opening opcode byte of the next instruction. A flush empties the queue and loads a new fetch address. Data that returns afterwards for a fetch issued before the flush is thrown away.

The bus side has one fetch outstanding at a time. A request is accepted in the cycle where `fetch_req` and `fetch_ack` are both high. The matching data comes back later as a single `rsp_valid` pulse. For a two-byte fetch, the byte at the lower address is in `rsp_data[7:0]`. For a one-byte fetch, the byte is in `rsp_data[7:0]`.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty, `q_status` is 00, and fetching starts at `RESET_ADDR`.
- R2: `fetch_word` is 1 (two bytes) when `fetch_addr[0]` is 0 and 0 (one byte) when it is 1. After an accepted request, `fetch_addr` advances by 2 or by 1 to match.
- R3: `fetch_req` is high only when all three hold: at least two of the `DEPTH` (6) slots are free, no fetch is outstanding, and `flush` is low. The byte count never exceeds `DEPTH`.
- R4: Bytes leave the queue on `pop_data` in fetch order, and the low byte of a two-byte fetch leaves first.
- R5: A pop that takes a byte reports 01 if that byte is the first after reset, after a flush, or after a pop with `pop_last` high. Otherwise it reports 11.
- R6: A cycle with `flush` high reports 10 and ignores `pop`. In the next cycle the queue is empty and `fetch_addr` equals the flushed address.
- R7: A cycle with neither a flush nor a pop of an available byte reports 00. A pop on an empty queue leaves the queue and the first-byte tracking unchanged.
- R8: Data returned for a request accepted before a flush is never placed in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the queue and load `flush_addr` |
| flush_addr | input | AW | New fetch address |
| fetch_req | output | 1 | Fetch request to the bus side |
| fetch_ack | input | 1 | Bus side accepts the request this cycle |
| fetch_addr | output | AW | Address of the requested code |
| fetch_word | output | 1 | 1 = two bytes, 0 = one byte |
| rsp_valid | input | 1 | Returned code is valid this cycle |
| rsp_data | input | 16 | Returned code, lower-address byte in bits 7:0 |
| pop | input | 1 | Consumer takes the head byte |
| pop_last | input | 1 | The popped byte ends its instruction |
| pop_data | output | 8 | Head byte of the queue |
| q_empty | output | 1 | Queue holds no byte |
| q_status | output | 2 | 00 idle, 01 first opcode byte, 10 emptied, 11 later byte |

## Verification
A wrong read or write pointer appears on `pop_data` at the very next pop. It shows up as a byte that differs from the expected code stream at that address. A drifting byte count appears within a few cycles in one of two ways: `q_empty` does not match, or `fetch_req` rises or falls at the wrong fill level. A stale fetch that is not discarded shows up as foreign bytes right after a flush. A lost first-byte flag appears as a wrong `q_status` on the pop that follows an instruction end.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 6,
  parameter int AW = 20,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  output logic          fetch_req,
  input  logic          fetch_ack,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_word,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  input  logic          pop,
  input  logic          pop_last,
  output logic [7:0]    pop_data,
  output logic          q_empty,
  output logic [1:0]    q_status
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          pend, pend_word, discard, at_first;
  logic          pop_ok, push_ok;
  logic [CW-1:0] push_n;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign q_empty    = (cnt == '0);
  assign pop_ok     = pop && !flush && !q_empty;
  assign push_ok    = rsp_valid && pend && !discard && !flush;
  assign push_n     = push_ok ? (pend_word ? CW'(2) : CW'(1)) : '0;
  assign fetch_word = ~fetch_addr[0];
  assign fetch_req  = !flush && !pend && ((CW'(DEPTH) - cnt) >= CW'(2));
  assign pop_data   = mem[rd_ptr];
  assign q_status   = flush ? 2'b10 : pop_ok ? (at_first ? 2'b01 : 2'b11) : 2'b00;

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= rsp_data[7:0];
      if (pend_word) mem[nxt(wr_ptr)] <= rsp_data[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      cnt        <= '0;
      fetch_addr <= RESET_ADDR;
      pend       <= 1'b0;
      pend_word  <= 1'b0;
      discard    <= 1'b0;
      at_first   <= 1'b1;
    end else if (flush) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      cnt        <= '0;
      fetch_addr <= flush_addr;
      at_first   <= 1'b1;
      if (pend) begin
        pend    <= !rsp_valid;
        discard <= !rsp_valid;
      end
    end else begin
      if (pop_ok) begin
        rd_ptr   <= nxt(rd_ptr);
        at_first <= pop_last;
      end
      if (push_ok) wr_ptr <= pend_word ? nxt(nxt(wr_ptr)) : nxt(wr_ptr);
      if (rsp_valid && pend) begin
        pend    <= 1'b0;
        discard <= 1'b0;
      end
      if (fetch_req && fetch_ack) begin
        pend       <= 1'b1;
        pend_word  <= fetch_word;
        fetch_addr <= fetch_addr + (fetch_word ? AW'(2) : AW'(1));
      end
      cnt <= cnt + push_n - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int DEPTH = 6,
  parameter int AW = 20,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [AW-1:0] flush_addr,
  input logic          fetch_req,
  input logic          fetch_ack,
  input logic [AW-1:0] fetch_addr,
  input logic          fetch_word,
  input logic          q_empty,
  input logic [1:0]    q_status,
  input logic [CW-1:0] cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R3
  AST_NO_REQ_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) fetch_req |-> !flush); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack) |=> !fetch_req); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack) |=> fetch_addr == $past(fetch_addr) + ($past(fetch_word) ? AW'(2) : AW'(1))); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> q_empty); // R6
  AST_FLUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fetch_addr == $past(flush_addr)); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !flush) |-> q_status == 2'b00); // R7
endmodule

bind prefetch_queue prefetch_queue_chk #(
  .DEPTH(DEPTH), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
  .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_addr(fetch_addr),
  .fetch_word(fetch_word), .q_empty(q_empty), .q_status(q_status), .cnt(cnt)
);

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;
  localparam int AW = 20;
  localparam logic [AW-1:0] START = 20'h00103;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 1'b0, fetch_ack = 1'b0, rsp_valid = 1'b0, pop = 1'b0, pop_last = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic [15:0] rsp_data = '0;
  logic fetch_req, fetch_word, q_empty;
  logic [AW-1:0] fetch_addr;
  logic [7:0] pop_data;
  logic [1:0] q_status;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] qm [8];
  int qc = 0;
  logic [AW-1:0] fa = START;
  bit pend = 0, disc = 0, first = 1;
  bit bus_busy = 0, bus_word = 0;
  int bus_cnt = 0;
  logic [AW-1:0] bus_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_queue #(.DEPTH(DEPTH), .AW(AW), .RESET_ADDR(START)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_addr(fetch_addr),
    .fetch_word(fetch_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pop(pop), .pop_last(pop_last), .pop_data(pop_data), .q_empty(q_empty),
    .q_status(q_status)
  );

  function automatic logic [7:0] code_at(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit pl, input bit fl, input logic [AW-1:0] fadr, input bit ack);
    bit exp_req, popv, rv;
    logic [1:0] exp_st;
    @(negedge clk);
    rv = bus_busy && bus_cnt == 0;
    pop = p; pop_last = pl; flush = fl; flush_addr = fadr; fetch_ack = ack;
    rsp_valid = rv;
    rsp_data = bus_word ? {code_at(bus_addr + AW'(1)), code_at(bus_addr)} : {8'h00, code_at(bus_addr)};
    #1;
    exp_req = !fl && !pend && (DEPTH - qc >= 2);
    popv = p && !fl && qc > 0;
    exp_st = fl ? 2'b10 : popv ? (first ? 2'b01 : 2'b11) : 2'b00;
    chk(fetch_req == exp_req, "R3 fetch_req", fetch_req, exp_req);
    chk(q_status == exp_st, popv ? "R5 status" : (fl ? "R6 status" : "R7 status"), q_status, exp_st);
    chk(q_empty == (qc == 0), "R7 q_empty", q_empty, qc == 0);
    if (exp_req) begin
      chk(fetch_addr == fa, "R2 fetch_addr", fetch_addr, fa);
      chk(fetch_word == !fa[0], "R2 fetch_word", fetch_word, !fa[0]);
    end
    if (popv) chk(pop_data == qm[0], "R4 pop_data", pop_data, qm[0]);
    // model update for the coming edge
    if (fl) begin
      qc = 0; fa = fadr; first = 1;
      if (pend) begin pend = !rv; disc = !rv; end
    end else begin
      if (popv) begin
        for (int i = 0; i < 7; i++) qm[i] = qm[i+1];
        qc--; first = pl;
      end
      if (rv && pend) begin
        if (!disc) begin
          qm[qc] = code_at(bus_addr); qc++;
          if (bus_word) begin qm[qc] = code_at(bus_addr + AW'(1)); qc++; end
        end
        pend = 0; disc = 0;
      end
      if (exp_req && ack) begin
        pend = 1;
        fa = fa + (fa[0] ? AW'(1) : AW'(2));
      end
    end
    if (rv) bus_busy = 0;
    if (exp_req && ack && !fl) begin
      bus_busy = 1; bus_cnt = $urandom % 3; bus_addr = fetch_addr; bus_word = fetch_word;
    end else if (bus_busy) bus_cnt--;
  endtask

  initial begin
    void'($urandom(32'd7041));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(q_status == 2'b00, "R1 reset status", q_status, 0);
    chk(q_empty == 1'b1, "R1 reset empty", q_empty, 1);
    chk(fetch_addr == START, "R1 reset addr", fetch_addr, START);
    chk(fetch_req == 1'b1, "R1 reset req", fetch_req, 1);
    // R7: pop on empty queue, no ack yet
    step(1, 1, 0, '0, 0);
    step(1, 0, 0, '0, 1);
    repeat (8) step(0, 0, 0, '0, 1);
    // fill to the brim with no pops, R3 room limit
    repeat (12) step(0, 0, 0, '0, 1);
    repeat (4) step(1, 0, 0, '0, 1);
    // R8: flush while a fetch is outstanding
    step(0, 0, 0, '0, 1);
    step(1, 0, 1, 20'h0A100, 1);
    repeat (10) step(1, ($urandom % 3) == 0, 0, '0, 1);
    // R6: flush to an odd address with a pop in the same cycle
    step(1, 0, 1, 20'h0F2F1, 1);
    repeat (8) step(1, 1, 0, '0, 1);
    for (int n = 0; n < 3000; n++) begin
      bit fl = ($urandom % 40) == 0;
      step(($urandom % 3) != 0, ($urandom % 4) == 0, fl,
           AW'($urandom), ($urandom % 4) != 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule